// File: doc/BRIEF.md
# Three-wire radio configuration loader

The block writes a complete set of configuration words into an external radio chip over three lines: a serial clock, a serial data line and a latch line. A two-bit mode input chooses which of three built-in tables is sent: one for receive, one for transmit and one for power-down. Each table holds eight 16-bit words. A one-cycle start pulse launches the sequence. A one-cycle done pulse marks the end, after the eighth word has been latched.

Every word is shifted out most significant bit first, so its high byte goes out before its low byte. The data line changes while the serial clock is high. The clock then falls and rises again, so the radio samples each bit on the rising edge. After the last bit of a word, the clock stays low. The latch line then rises, the clock rises while the latch is still high, and the latch falls. Every line step lasts a programmable number of system clock cycles (the half-period), which gives the serial clock a duty cycle of about 50%.

No data streams through the block's edge. Start, mode and the half-period are plain control pins, with no valid/ready handshake and no back-pressure.

Top module: `xcvr_cfg_loader`

## Requirements
- R1: After reset, and whenever no sequence is running, cfg_sclk, cfg_latch, cfg_sdata and done are all 0.
- R2: A start seen high at a rising edge while idle makes cfg_sclk 1 and cfg_latch 0 from that same edge. This preparation step lasts H cycles, where H is the half-period.
- R3: The table byte at index i (0..15) for a mode is SEED ^ ((i*8'h1D) mod 256). SEED is 8'h3C for mode 0 (receive), 8'hA5 for mode 1 (transmit) and 8'h5A for mode 2 (power-down); mode 3 also selects the power-down table. Word w is {byte 2w, byte 2w+1}, and it is sent from bit 15 down to bit 0.
- R4: Each bit takes two steps of H cycles each. In the first step the data line carries the bit while cfg_sclk is 1. In the second step cfg_sclk is 0 and the data is held.
- R5: After bit 0 of a word, cfg_sclk stays 0. The latch then runs three steps of H cycles each: latch 1 with clock 0, then latch 1 with clock 1, then latch 0 with clock 1. The data line holds bit 0 of the word through all three steps.
- R6: Exactly eight words are sent, so a run lasts 281*H cycles. In the cycle right after the last latch step, all lines are 0 and done is 1, for exactly one cycle.
- R7: A start that arrives while a sequence is running is ignored, and the sequence it interrupts is not disturbed. A start in the done cycle launches a new sequence.
- R8: Mode and half-period are captured when a sequence starts; changing them during a run has no effect on that run. A half-period of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled while idle |
| mode | input | 2 | Table select: 0 receive, 1 transmit, 2 or 3 power-down |
| half_period | input | HP_W (8) | System cycles per line step (0 treated as 1) |
| cfg_sclk | output | 1 | Serial configuration clock |
| cfg_sdata | output | 1 | Serial configuration data |
| cfg_latch | output | 1 | Word latch line |
| done | output | 1 | One-cycle pulse when the last word has been latched |

## Verification
The lines are decoded from registered state, so they show the preparation step in the cycle after the edge that sampled start. After that, each step lasts H cycles, and done is due 281*H cycles after that edge. The bench expands each accepted start into a queue that holds one expected line value per cycle. It pops one entry per clock and compares it with the outputs at the falling edge, halfway between the edges that move the design. A start is accepted into the queue only when the model is idle, which is the same rule the design applies, so ignored starts and a restart in the done cycle are timed exactly.

// File: rtl/xcvr_cfg_pkg.sv
package xcvr_cfg_pkg;

  typedef enum logic [1:0] {
    MODE_RX = 2'd0,
    MODE_TX = 2'd1,
    MODE_PD = 2'd2
  } cfg_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PREP     = 3'd1,
    ST_BIT_HI   = 3'd2,
    ST_BIT_LO   = 3'd3,
    ST_LAT_RISE = 3'd4,
    ST_LAT_CLK  = 3'd5,
    ST_LAT_FALL = 3'd6
  } seq_state_t;

endpackage

// File: rtl/xcvr_cfg_rom.sv
module xcvr_cfg_rom #(
  parameter int          NUM_WORDS = 8,
  parameter int          WORD_W    = 16,
  parameter int          WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  parameter logic [7:0]  SEED_RX   = 8'h3C,
  parameter logic [7:0]  SEED_TX   = 8'hA5,
  parameter logic [7:0]  SEED_PD   = 8'h5A,
  parameter logic [7:0]  BYTE_STEP = 8'h1D
) (
  input  logic [1:0]        mode,
  input  logic [WIDX_W-1:0] word_idx,
  output logic [WORD_W-1:0] word
);
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam int NUM_TABLES     = 3;

  function automatic logic [7:0] seed_of(input int m);
    case (m)
      0:       seed_of = SEED_RX;
      1:       seed_of = SEED_TX;
      default: seed_of = SEED_PD;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input int m, input int w);
    logic [WORD_W-1:0] acc;
    acc = '0;
    for (int b = 0; b < BYTES_PER_WORD; b++) begin
      acc = {acc[WORD_W-9:0], seed_of(m) ^ 8'((w * BYTES_PER_WORD + b) * int'(BYTE_STEP))};
    end
    word_of = acc;
  endfunction

  logic [WORD_W-1:0] table_words [NUM_TABLES][NUM_WORDS];

  for (genvar gm = 0; gm < NUM_TABLES; gm++) begin : g_table
    for (genvar gw = 0; gw < NUM_WORDS; gw++) begin : g_word
      assign table_words[gm][gw] = word_of(gm, gw);
    end
  end

  always_comb begin
    case (mode)
      2'd0:    word = table_words[0][word_idx];
      2'd1:    word = table_words[1][word_idx];
      default: word = table_words[2][word_idx];
    endcase
  end

endmodule

// File: rtl/xcvr_cfg_timer.sv
module xcvr_cfg_timer #(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [HP_W-1:0] limit_m1,
  output logic            tick
);
  logic [HP_W-1:0] count_q;

  assign tick = active && (count_q == limit_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (!active || tick) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/xcvr_cfg_seq.sv
module xcvr_cfg_seq
  import xcvr_cfg_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 16,
  parameter int HP_W      = 8,
  parameter int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  parameter int BIT_W     = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [HP_W-1:0]   half_period,
  input  logic              tick,
  input  logic [WORD_W-1:0] word,
  output logic [1:0]        mode_sel,
  output logic [WIDX_W-1:0] word_idx,
  output logic              active,
  output logic [HP_W-1:0]   limit_m1,
  output logic              sclk,
  output logic              sdata,
  output logic              latch,
  output logic              done
);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(NUM_WORDS - 1);

  seq_state_t        state_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WIDX_W-1:0] word_q;
  logic [1:0]        mode_q;
  logic [HP_W-1:0]   hp_m1_q;
  logic              done_q;
  logic [BIT_W-1:0]  bit_sel;
  logic              cur_bit;

  assign mode_sel = mode_q;
  assign word_idx = word_q;
  assign active   = (state_q != ST_IDLE);
  assign limit_m1 = hp_m1_q;
  assign done     = done_q;
  assign bit_sel  = LAST_BIT - bit_q;
  assign cur_bit  = word[bit_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      word_q  <= '0;
      mode_q  <= MODE_RX;
      hp_m1_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_PREP;
            mode_q  <= mode;
            hp_m1_q <= (half_period == '0) ? '0 : half_period - 1'b1;
            bit_q   <= '0;
            word_q  <= '0;
          end
        end
        ST_PREP: begin
          if (tick) state_q <= ST_BIT_HI;
        end
        ST_BIT_HI: begin
          if (tick) state_q <= ST_BIT_LO;
        end
        ST_BIT_LO: begin
          if (tick) begin
            if (bit_q == LAST_BIT) begin
              state_q <= ST_LAT_RISE;
            end else begin
              bit_q   <= bit_q + 1'b1;
              state_q <= ST_BIT_HI;
            end
          end
        end
        ST_LAT_RISE: begin
          if (tick) state_q <= ST_LAT_CLK;
        end
        ST_LAT_CLK: begin
          if (tick) state_q <= ST_LAT_FALL;
        end
        ST_LAT_FALL: begin
          if (tick) begin
            if (word_q == LAST_WORD) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              word_q  <= word_q + 1'b1;
              bit_q   <= '0;
              state_q <= ST_BIT_HI;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sclk  = 1'b0;
    latch = 1'b0;
    sdata = 1'b0;
    case (state_q)
      ST_PREP:     sclk = 1'b1;
      ST_BIT_HI:   begin sclk = 1'b1; sdata = cur_bit; end
      ST_BIT_LO:   sdata = cur_bit;
      ST_LAT_RISE: begin latch = 1'b1; sdata = word[0]; end
      ST_LAT_CLK:  begin sclk = 1'b1; latch = 1'b1; sdata = word[0]; end
      ST_LAT_FALL: begin sclk = 1'b1; sdata = word[0]; end
      default: ;
    endcase
  end

endmodule

// File: rtl/xcvr_cfg_loader.sv
module xcvr_cfg_loader #(
  parameter int         NUM_WORDS = 8,
  parameter int         WORD_W    = 16,
  parameter int         HP_W      = 8,
  parameter logic [7:0] SEED_RX   = 8'h3C,
  parameter logic [7:0] SEED_TX   = 8'hA5,
  parameter logic [7:0] SEED_PD   = 8'h5A,
  parameter logic [7:0] BYTE_STEP = 8'h1D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [HP_W-1:0] half_period,
  output logic            cfg_sclk,
  output logic            cfg_sdata,
  output logic            cfg_latch,
  output logic            done
);
  localparam int WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [1:0]        mode_sel;
  logic [WIDX_W-1:0] word_idx;
  logic [WORD_W-1:0] word;
  logic              active;
  logic [HP_W-1:0]   limit_m1;
  logic              tick;

  xcvr_cfg_rom #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .WIDX_W(WIDX_W),
    .SEED_RX(SEED_RX), .SEED_TX(SEED_TX), .SEED_PD(SEED_PD),
    .BYTE_STEP(BYTE_STEP)
  ) u_rom (
    .mode(mode_sel), .word_idx(word_idx), .word(word)
  );

  xcvr_cfg_timer #(.HP_W(HP_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(active),
    .limit_m1(limit_m1), .tick(tick)
  );

  xcvr_cfg_seq #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .HP_W(HP_W), .WIDX_W(WIDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .half_period(half_period), .tick(tick), .word(word),
    .mode_sel(mode_sel), .word_idx(word_idx), .active(active),
    .limit_m1(limit_m1), .sclk(cfg_sclk), .sdata(cfg_sdata),
    .latch(cfg_latch), .done(done)
  );

endmodule

// File: rtl/xcvr_cfg_loader_chk.sv
module xcvr_cfg_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_sclk,
  input logic cfg_sdata,
  input logic cfg_latch,
  input logic done
);

  p_latch_rise_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_latch) |-> !cfg_sclk);

  p_latch_fall_clk_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_latch) |-> cfg_sclk);

  p_latch_edge_clk_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_latch) || $fell(cfg_latch)) |-> $stable(cfg_sclk));

  p_data_held_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sclk && !$past(cfg_sclk)) |-> $stable(cfg_sdata));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_lines_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cfg_sclk && !cfg_latch && !cfg_sdata));

  p_done_after_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cfg_sclk) && !$past(cfg_latch)));

endmodule

bind xcvr_cfg_loader xcvr_cfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sclk(cfg_sclk), .cfg_sdata(cfg_sdata),
  .cfg_latch(cfg_latch), .done(done)
);

// File: tb/xcvr_cfg_loader_tb.sv
`timescale 1ns/1ps
module xcvr_cfg_loader_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] half_period = 8'd1;
  logic       cfg_sclk, cfg_sdata, cfg_latch, done;

  int checks = 0;
  int failures = 0;
  int done_count = 0;
  string ctx = "R1";

  logic [2:0] exp_q[$];
  string      tag_q[$];
  bit         cur_active = 0;

  always #2.5 clk = ~clk;

  xcvr_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .half_period(half_period), .cfg_sclk(cfg_sclk), .cfg_sdata(cfg_sdata),
    .cfg_latch(cfg_latch), .done(done)
  );

  function automatic logic [7:0] ref_byte(input int m, input int i);
    logic [7:0] seed;
    seed = (m == 0) ? 8'h3C : (m == 1) ? 8'hA5 : 8'h5A;
    return seed ^ 8'((i * 29) % 256);
  endfunction

  task automatic push(input int n, input logic s, input logic l, input logic d, input string t);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({s, l, d});
      tag_q.push_back(t);
    end
  endtask

  task automatic build(input int m, input int hp);
    int h;
    logic [15:0] w16;
    h = (hp == 0) ? 1 : hp;
    push(h, 1'b1, 1'b0, 1'b0, "R2");
    for (int w = 0; w < 8; w++) begin
      w16 = {ref_byte(m, 2*w), ref_byte(m, 2*w+1)};
      for (int b = 15; b >= 0; b--) begin
        push(h, 1'b1, 1'b0, w16[b], "R3");
        push(h, 1'b0, 1'b0, w16[b], "R4");
      end
      push(h, 1'b0, 1'b1, w16[0], "R5");
      push(h, 1'b1, 1'b1, w16[0], "R5");
      push(h, 1'b1, 1'b0, w16[0], "R5");
    end
  endtask

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", tag, ctx, $time, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && start && exp_q.size() == 0 && !cur_active) build(int'(mode), int'(half_period));
  end

  always @(negedge clk) begin
    logic [2:0] e;
    string t;
    logic ed;
    if (!rst_n) begin
      cur_active = 0;
    end else begin
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        ed = 1'b0;
        cur_active = 1;
      end else begin
        e = 3'b000;
        t = "R1";
        ed = cur_active;
        cur_active = 0;
      end
      check(t, {cfg_sclk, cfg_latch, cfg_sdata}, e);
      check("R6", done, ed);
      if (done) done_count++;
    end
  end

  task automatic launch(input int m, input int hp);
    @(negedge clk);
    start = 1'b1; mode = 2'(m); half_period = 8'(hp);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    ctx = "R1 reset state";
    check("R1", {cfg_sclk, cfg_latch, cfg_sdata, done}, 0);
    idle_wait(3);

    ctx = "R3 receive table H=2";
    launch(0, 2);
    idle_wait(281*2 + 4);
    check("R6", done_count, 1);

    ctx = "R7 R8 transmit H=1 with restarts and input changes";
    launch(1, 1);
    idle_wait(20);
    start = 1'b1; mode = 2'd2; half_period = 8'd5;
    @(negedge clk); start = 1'b0;
    idle_wait(100);
    start = 1'b1;
    @(negedge clk); start = 1'b0; mode = 2'd0;
    idle_wait(281 + 4);
    check("R7", done_count, 2);

    ctx = "R8 zero half-period, mode 3 selects power-down";
    launch(3, 0);
    idle_wait(281 + 4);
    check("R8", done_count, 3);

    ctx = "R7 restart in done cycle";
    launch(2, 1);
    idle_wait(281);
    start = 1'b1; mode = 2'd1; half_period = 8'd3;
    @(negedge clk); start = 1'b0;
    idle_wait(281*3 + 4);
    check("R7", done_count, 5);

    ctx = "R1 idle after runs";
    idle_wait(5);
    check("R1", {cfg_sclk, cfg_latch, cfg_sdata, done}, 0);
    finish_run();
  end

endmodule